// File: doc/BRIEF.md
# Vertical-blank DMA request queue

This block gathers video-memory copy requests from a producer while the picture is being drawn and holds them until vertical blank begins. At that moment it hands every stored request, oldest first, to the control port of a DMA engine. All the transfer work is then packed into the blanking interval, and the producer never has to wait for blanking itself.

Each request carries a byte source address, a byte length, a 16-bit destination address and a 2-bit target select: 0 tile RAM, 1 colour RAM, 2 scroll RAM, 3 treated as tile RAM. When a request is accepted the block converts source and length to word units. If the word range would run past a 64K-word (128KB) source page, it stores two entries in place of one. The first entry ends exactly on the page edge and the second starts at the next page.

For each stored entry the block first waits for the engine to report idle. It then writes seven control words on consecutive cycles: five register loads followed by the two-word destination command. The register numbers 0x93 to 0x97 and the command layout are fixed by the engine that decodes them.

Top module: `vbdma_queue`

The block is built from four state machine states.
- S_IDLE accepts requests. It leaves for S_WAIT on a rising edge of `vblank`.
- S_WAIT moves to S_FINISH when the queue is empty. Otherwise it moves to S_EMIT once `port_busy` is low.
- S_EMIT steps through the seven words. After the last word it removes the entry and returns to S_WAIT.
- S_FINISH raises `done` for one cycle and returns to S_IDLE.

## Requirements
- R1: After reset `req_ready` is 1, and `port_wr`, `done` and `overflow` are 0.
- R2: A stored word source is byte source bit 23 down to bit 1, a 23-bit value. A stored word length is byte length bit 16 down to bit 1.
- R3: Each entry is emitted as seven writes on consecutive cycles. The first five are 0x93 with length bits 7:0, then 0x94 with length bits 15:8, then 0x95 with source bits 7:0, then 0x96 with source bits 15:8, then 0x97 with a 0 bit followed by source bits 22:16. Each value sits in the upper byte, with the data in the lower byte.
- R4: The sixth word is {2'b11 for colour RAM or 2'b01 otherwise, dst[13:0]}. The seventh word is 0x0080, plus 0x0010 for scroll RAM, plus dst[15:14] in bits 1:0.
- R5: A request crosses a page when the low 16 bits of its word source plus its word length exceed 0x10000. It is then stored as two entries. The first has length 0x10000 minus the low 16 source bits. The second has the source of the next 64K-word page, the remaining length, and a destination advanced by twice the first length (modulo 2^16). A range that ends exactly on the page edge is not split.
- R6: No control word is written until `vblank` rises. Draining starts only on a rising edge of `vblank`.
- R7: The first write of each entry happens only in the cycle after `port_busy` was seen low.
- R8: Entries leave in the order they were stored.
- R9: `req_ready` is 0 from the cycle after the `vblank` rising edge until the cycle `done` is high.
- R10: The queue holds 16 entries. A request is accepted only when there is room for all the entries it makes: one entry, or two for a split request.
- R11: A request that is offered while idle and refused for lack of room is dropped, and it sets `overflow`. Once set, `overflow` stays set until reset. Refusal during draining does not set it.
- R12: `done` is high for exactly one cycle when the drain finds the queue empty. This includes a drain that starts with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request is taken on this edge when valid |
| req_src | input | 24 | Source byte address |
| req_len | input | 17 | Length in bytes |
| req_dst | input | 16 | Destination byte address |
| req_tgt | input | 2 | Target memory: 0 tile, 1 colour, 2 scroll, 3 tile |
| vblank | input | 1 | Vertical blank level; its rising edge starts a drain |
| port_busy | input | 1 | Engine is still copying |
| port_wr | output | 1 | Control word strobe |
| port_data | output | 16 | Control word |
| done | output | 1 | One-cycle pulse when the drain empties the queue |
| overflow | output | 1 | Sticky flag: a request was dropped |

## Verification
The main function is tried with a batch of six requests that together make eight entries. The batch includes the following patterns:
- a plain aligned transfer;
- an odd source with a garbage top bit, which separates the bit-drop from the 23-bit mask;
- each of the three target codes plus the alias code, which separates the two command-word encodings;
- a range ending exactly on a page edge, which must stay whole;
- two crossing ranges, one of them with a destination that wraps past 0xFFFF, which check both halves of the split.

Further patterns cover the rest:
- holding the engine busy shows that emission waits on it;
- offering a request during draining shows the refusal;
- draining an empty queue shows the lone done pulse;
- filling to fifteen entries and then offering a split request, followed by a single one, separates the two-slot rule from the one-slot rule and shows the sticky drop flag.

// File: rtl/vbq_pkg.sv
package vbq_pkg;

    localparam int SRC_BW  = 24;   // byte source width
    localparam int LEN_BW  = 17;   // byte length width
    localparam int DST_W   = 16;   // destination width
    localparam int WSRC_W  = SRC_BW - 1;
    localparam int WLEN_W  = LEN_BW - 1;
    localparam int PAGE_W  = 16;   // words per source page = 2**PAGE_W
    localparam int BANK_W  = WSRC_W - PAGE_W;
    localparam logic [PAGE_W:0] PAGE_SPAN = {1'b1, {PAGE_W{1'b0}}};

    localparam logic [1:0] TGT_COLOUR = 2'd1;
    localparam logic [1:0] TGT_SCROLL = 2'd2;

    // register numbers decoded by the engine, in emission order
    localparam logic [7:0] REG_LEN_LO = 8'h93;
    localparam logic [7:0] REG_LEN_HI = 8'h94;
    localparam logic [7:0] REG_SRC_LO = 8'h95;
    localparam logic [7:0] REG_SRC_MI = 8'h96;
    localparam logic [7:0] REG_SRC_HI = 8'h97;

    localparam int WORDS_PER_XFER = 7;
    localparam logic [2:0] LAST_WORD = 3'(WORDS_PER_XFER - 1);

    typedef struct packed {
        logic [WSRC_W-1:0] src;
        logic [WLEN_W-1:0] len;
        logic [DST_W-1:0]  dst;
        logic [1:0]        tgt;
    } xfer_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT,
        S_EMIT,
        S_FINISH
    } drain_st_e;

    function automatic logic [15:0] emit_word(input xfer_t e, input logic [2:0] idx);
        logic [15:0] w;
        case (idx)
            3'd0:    w = {REG_LEN_LO, e.len[7:0]};
            3'd1:    w = {REG_LEN_HI, e.len[15:8]};
            3'd2:    w = {REG_SRC_LO, e.src[7:0]};
            3'd3:    w = {REG_SRC_MI, e.src[15:8]};
            3'd4:    w = {REG_SRC_HI, 1'b0, e.src[22:16]};
            3'd5:    w = {(e.tgt == TGT_COLOUR) ? 2'b11 : 2'b01, e.dst[13:0]};
            3'd6:    w = {8'h00, 1'b1, 2'b00, (e.tgt == TGT_SCROLL), 2'b00, e.dst[15:14]};
            default: w = 16'h0000;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/vbq_split.sv
module vbq_split
    import vbq_pkg::*;
(
    input  logic [SRC_BW-1:0] src_b,
    input  logic [LEN_BW-1:0] len_b,
    input  logic [DST_W-1:0]  dst_b,
    input  logic [1:0]        tgt,
    output xfer_t             part_a,
    output xfer_t             part_b,
    output logic              crosses
);

    logic [WSRC_W-1:0] wsrc;
    logic [WLEN_W-1:0] wlen;
    logic [PAGE_W:0]   end_off;
    logic [PAGE_W:0]   head_full;
    logic [WLEN_W-1:0] head_len;
    logic              unused_bits;

    // dropping bit 0 converts to words; the width keeps 23 bits of source
    assign wsrc      = src_b[SRC_BW-1:1];
    assign wlen      = len_b[LEN_BW-1:1];
    assign end_off   = {1'b0, wsrc[PAGE_W-1:0]} + {1'b0, wlen};
    assign crosses   = end_off > PAGE_SPAN;
    assign head_full = PAGE_SPAN - {1'b0, wsrc[PAGE_W-1:0]};
    assign head_len  = head_full[WLEN_W-1:0];
    assign unused_bits = src_b[0] ^ len_b[0] ^ head_full[PAGE_W];

    always_comb begin
        part_a.src = wsrc;
        part_a.len = crosses ? head_len : wlen;
        part_a.dst = dst_b;
        part_a.tgt = tgt;

        part_b.src = {wsrc[WSRC_W-1:PAGE_W] + BANK_W'(1), {PAGE_W{1'b0}}};
        part_b.len = wlen - head_len;
        part_b.dst = dst_b + {head_len[DST_W-2:0], 1'b0};
        part_b.tgt = tgt;
    end

endmodule

// File: rtl/vbq_store.sv
module vbq_store
    import vbq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   push_n,
    input  xfer_t                        in_a,
    input  xfer_t                        in_b,
    input  logic                         pop,
    output xfer_t                        head,
    output logic [$clog2(DEPTH+1)-1:0]   fill
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    xfer_t            mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [AW-1:0]    rptr;
    logic [AW-1:0]    wptr_nx;

    assign wptr_nx = wptr + AW'(1);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wptr] <= in_a;
        if (push_n == 2'd2) mem[wptr_nx] <= in_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            wptr <= wptr + AW'(push_n);
            rptr <= rptr + AW'(pop);
            fill <= fill + CW'(push_n) - CW'(pop);
        end
    end

endmodule

// File: rtl/vbq_drain.sv
module vbq_drain
    import vbq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vblank,
    input  logic        port_busy,
    input  logic        empty,
    input  xfer_t       head,
    output logic        port_wr,
    output logic [15:0] port_data,
    output logic        pop,
    output logic        done,
    output logic        draining
);

    drain_st_e  state, state_nx;
    logic [2:0] idx, idx_nx;
    logic       vb_q;
    logic       vb_rise;

    assign vb_rise = vblank & ~vb_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            vb_q  <= 1'b0;
        end else begin
            state <= state_nx;
            idx   <= idx_nx;
            vb_q  <= vblank;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        idx_nx   = idx;
        unique case (state)
            S_IDLE: begin
                if (vb_rise) state_nx = S_WAIT;
            end
            S_WAIT: begin
                if (empty) begin
                    state_nx = S_FINISH;
                end else if (!port_busy) begin
                    state_nx = S_EMIT;
                    idx_nx   = '0;
                end
            end
            S_EMIT: begin
                if (idx == LAST_WORD) state_nx = S_WAIT;
                else                  idx_nx   = idx + 3'd1;
            end
            S_FINISH: state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        port_wr   = 1'b0;
        port_data = 16'h0000;
        pop       = 1'b0;
        done      = 1'b0;
        draining  = 1'b1;
        unique case (state)
            S_IDLE:   draining = 1'b0;
            S_WAIT:   ;
            S_EMIT: begin
                port_wr   = 1'b1;
                port_data = emit_word(head, idx);
                pop       = (idx == LAST_WORD);
            end
            S_FINISH: done = 1'b1;
        endcase
    end

endmodule

// File: rtl/vbdma_queue.sv
module vbdma_queue
    import vbq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SRC_BW-1:0] req_src,
    input  logic [LEN_BW-1:0] req_len,
    input  logic [DST_W-1:0]  req_dst,
    input  logic [1:0]        req_tgt,
    input  logic              vblank,
    input  logic              port_busy,
    output logic              port_wr,
    output logic [15:0]       port_data,
    output logic              done,
    output logic              overflow
);

    localparam int FILL_W = $clog2(DEPTH + 1);

    xfer_t             part_a, part_b, head;
    logic              crosses;
    logic [FILL_W-1:0] fill;
    logic [FILL_W-1:0] room;
    logic              room_ok;
    logic              draining;
    logic              pop;
    logic [1:0]        push_n;

    vbq_split u_split (
        .src_b   (req_src),
        .len_b   (req_len),
        .dst_b   (req_dst),
        .tgt     (req_tgt),
        .part_a  (part_a),
        .part_b  (part_b),
        .crosses (crosses)
    );

    assign room      = FILL_W'(DEPTH) - fill;
    assign room_ok   = crosses ? (room >= FILL_W'(2)) : (room >= FILL_W'(1));
    assign req_ready = !draining && room_ok;
    assign push_n    = (req_valid && req_ready) ? (crosses ? 2'd2 : 2'd1) : 2'd0;

    vbq_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_n (push_n),
        .in_a   (part_a),
        .in_b   (part_b),
        .pop    (pop),
        .head   (head),
        .fill   (fill)
    );

    vbq_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank    (vblank),
        .port_busy (port_busy),
        .empty     (fill == '0),
        .head      (head),
        .port_wr   (port_wr),
        .port_data (port_data),
        .pop       (pop),
        .done      (done),
        .draining  (draining)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                                 overflow <= 1'b0;
        else if (req_valid && !draining && !room_ok) overflow <= 1'b1;
    end

endmodule

// File: rtl/vbdma_queue_chk.sv
module vbdma_queue_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          port_wr,
    input logic [15:0]   port_data,
    input logic          port_busy,
    input logic          done,
    input logic          overflow,
    input logic [CW-1:0] fill
);

    // R9
    no_accept_while_emitting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |-> !req_ready);

    // R12
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R7
    idle_engine_before_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_data[15:8] == 8'h93) |-> !$past(port_busy));

    // R3
    len_hi_follows_len_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && port_data[15:8] == 8'h93) |=> (port_wr && port_data[15:8] == 8'h94));

    // R10
    full_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH)) |-> !req_ready);

    // R10
    fill_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

endmodule

bind vbdma_queue vbdma_queue_chk #(.DEPTH(DEPTH), .CW(FILL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .port_wr   (port_wr),
    .port_data (port_data),
    .port_busy (port_busy),
    .done      (done),
    .overflow  (overflow),
    .fill      (fill)
);

// File: tb/vbdma_queue_test.sv
module vbdma_queue_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_src;
    logic [16:0] req_len;
    logic [15:0] req_dst;
    logic [1:0]  req_tgt;
    logic        vblank;
    logic        port_busy = 1'b0;
    logic        port_wr;
    logic [15:0] port_data;
    logic        done;
    logic        overflow;

    always #5 clk = ~clk;

    vbdma_queue uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_len(req_len), .req_dst(req_dst), .req_tgt(req_tgt),
        .vblank(vblank), .port_busy(port_busy), .port_wr(port_wr),
        .port_data(port_data), .done(done), .overflow(overflow)
    );

    // stimulus table: {src, len, dst, tgt}
    localparam int NVEC = 6;
    localparam logic [58:0] VEC [NVEC] = '{
        {24'h000200, 17'h00040, 16'h0020, 2'd0},
        {24'hFF0011, 17'h00011, 16'hC002, 2'd1},
        {24'h020000, 17'h00100, 16'h0004, 2'd2},
        {24'h01FFF0, 17'h00040, 16'h1000, 2'd0},
        {24'h01FFC0, 17'h00040, 16'h2000, 2'd3},
        {24'h3FFFFE, 17'h00004, 16'hFFFE, 2'd2}
    };

    int total = 0;
    int bad   = 0;
    int logw [256];
    int expw [256];
    int nlog = 0;
    int nexp = 0;
    int wcount = 0;
    int busy_cnt = 0;
    logic hold_busy = 1'b0;

    // engine model and write log, sampled away from the active edge
    always @(negedge clk) begin
        if (port_wr) begin
            if (nlog < 256) logw[nlog] = int'(port_data);
            nlog++;
            wcount++;
            if (wcount % 7 == 0) busy_cnt = 3;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        port_busy = hold_busy || (busy_cnt > 0);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add_entry(input int ws, input int wl, input int d, input int t);
        expw[nexp++] = 32'h9300 | (wl & 8'hFF);
        expw[nexp++] = 32'h9400 | ((wl >> 8) & 8'hFF);
        expw[nexp++] = 32'h9500 | (ws & 8'hFF);
        expw[nexp++] = 32'h9600 | ((ws >> 8) & 8'hFF);
        expw[nexp++] = 32'h9700 | ((ws >> 16) & 8'h7F);
        expw[nexp++] = ((t == 1) ? 32'hC000 : 32'h4000) | (d & 32'h3FFF);
        expw[nexp++] = 32'h0080 | ((t == 2) ? 32'h0010 : 32'h0) | ((d >> 14) & 3);
    endtask

    task automatic model(input int s, input int l, input int d, input int t);
        int ws, wl, a;
        ws = (s >> 1) & 32'h7FFFFF;
        wl = l >> 1;
        if ((ws & 32'hFFFF) + wl > 32'h10000) begin
            a = 32'h10000 - (ws & 32'hFFFF);
            add_entry(ws, a, d, t);
            add_entry(((ws | 32'hFFFF) + 1) & 32'h7FFFFF, wl - a, (d + 2 * a) & 32'hFFFF, t);
        end else begin
            add_entry(ws, wl, d, t);
        end
    endtask

    task automatic offer(input int s, input int l, input int d, input int t, output bit took);
        @(negedge clk);
        req_valid = 1'b1;
        req_src   = 24'(s);
        req_len   = 17'(l);
        req_dst   = 16'(d);
        req_tgt   = 2'(t);
        #1 took = req_ready;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        vblank = 1'b0;
        req_valid = 1'b0;
        req_src = '0; req_len = '0; req_dst = '0; req_tgt = '0;
        hold_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nlog = 0; wcount = 0; nexp = 0;
    endtask

    task automatic drain(input int hold_cycles);
        int n;
        bit seen;
        nlog = 0;
        wcount = 0;
        @(negedge clk);
        vblank = 1'b1;
        @(negedge clk);
        // R9: offer during draining must be refused
        req_valid = 1'b1;
        req_src = 24'h000100; req_len = 17'h2; req_dst = '0; req_tgt = '0;
        #1 check(req_ready == 1'b0, "R9 ready while draining", int'(req_ready), 0);
        req_valid = 1'b0;
        if (hold_cycles > 0) begin
            repeat (hold_cycles) @(negedge clk);
            check(nlog == 0, "R7 no write while engine busy", nlog, 0);
            hold_busy = 1'b0;
        end
        n = 0;
        seen = done;
        while (!seen && n < 4000) begin
            @(negedge clk);
            seen = done;
            n++;
        end
        check(seen, "R12 done pulse after drain", int'(seen), 1);
        @(negedge clk);
        check(done == 1'b0, "R12 done lasts one cycle", int'(done), 0);
        vblank = 1'b0;
        check(nlog == nexp, "R8 word count of drain", nlog, nexp);
        for (int k = 0; k < nexp && k < nlog; k++) begin
            if (k % 7 < 5)
                check(logw[k] == expw[k], "R2 R3 R8 register word", logw[k], expw[k]);
            else
                check(logw[k] == expw[k], "R4 R5 command word", logw[k], expw[k]);
        end
        nexp = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit took;
        do_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(port_wr == 1'b0, "R1 no write after reset", int'(port_wr), 0);
        check(done == 1'b0, "R1 done low after reset", int'(done), 0);
        check(overflow == 1'b0, "R1 overflow low after reset", int'(overflow), 0);

        // table walk: conversion, encoding, split, ordering
        for (int i = 0; i < NVEC; i++) begin
            offer(int'(VEC[i][58:35]), int'(VEC[i][34:18]), int'(VEC[i][17:2]),
                  int'(VEC[i][1:0]), took);
            check(took, "R10 accepted with room", int'(took), 1);
            model(int'(VEC[i][58:35]), int'(VEC[i][34:18]), int'(VEC[i][17:2]),
                  int'(VEC[i][1:0]));
        end
        repeat (10) @(negedge clk);
        check(nlog == 0, "R6 nothing written before vblank", nlog, 0);
        drain(0);

        // engine held busy: emission must wait
        offer(32'h004000, 32'h10, 32'h0100, 1, took);
        model(32'h004000, 32'h10, 32'h0100, 1);
        hold_busy = 1'b1;
        drain(8);

        // empty queue drain
        drain(0);
        check(overflow == 1'b0, "R11 refusal while draining is not a drop", int'(overflow), 0);

        // capacity and drop flag
        do_reset();
        for (int i = 0; i < 15; i++) begin
            offer(i * 32'h100, 4, i * 2, 0, took);
            check(took, "R10 fill to fifteen", int'(took), 1);
            model(i * 32'h100, 4, i * 2, 0);
        end
        check(overflow == 1'b0, "R11 no drop yet", int'(overflow), 0);
        offer(32'h01FFFC, 8, 32'h0300, 0, took);
        check(!took, "R10 split needs two slots", int'(took), 0);
        @(negedge clk);
        check(overflow == 1'b1, "R11 drop sets flag", int'(overflow), 1);
        offer(32'h00F000, 6, 32'h0400, 2, took);
        check(took, "R10 single fits last slot", int'(took), 1);
        model(32'h00F000, 6, 32'h0400, 2);
        offer(32'h00F100, 6, 32'h0500, 0, took);
        check(!took, "R10 full queue refuses", int'(took), 0);
        drain(0);
        check(overflow == 1'b1, "R11 flag stays set", int'(overflow), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule